// File: doc/BRIEF.md
# CAN Controller Status Word and Status Interrupt

This block keeps the status word of a CAN controller and decides when that word raises the controller's status interrupt. The protocol engine reports bus events to it as single-cycle pulses: a frame sent, a frame received, an error classification with a 3-bit code, and a run of 11 recessive bits seen during bus-off recovery. It also drives three levels: error-passive, error-warning and bus-off. Two enable bits taken from the controller's control register decide which kind of event may raise the interrupt.

The CPU sees one register. A write strobe updates the writable fields: the two success flags and the error code. A read strobe marks the moment the CPU reads the word, and that read acknowledges a pending status interrupt. The block drives a 16-bit interrupt identifier and a single interrupt line. Bit timing, frame coding, CRC checking and error counting happen upstream. Their results arrive here only as pulses and levels.

Top module: `can_stat_irq`

## Requirements
- R1: After a synchronous active-low reset, the status word is 0x00, `irq` is low and `irq_id` is 0x0000.
- R2: Status bit 3 (sent-OK) and bit 4 (received-OK) are set by their event pulses. They keep their value until a CPU write loads them from `cpu_wdata[3]` and `cpu_wdata[4]`.
- R3: On an error-report pulse, bits 2:0 take the reported code unchanged. The codes are: 0 none, 1 stuff (more than five equal bits in a row where stuffing applies), 2 form, 3 acknowledge, 4 bit-1, 5 bit-0, 6 CRC, 7 idle (no bus event since the CPU wrote 7). The field holds its value between events.
- R4: A recovery-run pulse (11 recessive bits during bus-off recovery) loads code 5 into bits 2:0. An error-report pulse in the same cycle takes precedence.
- R5: Bit 5 shows error-passive, bit 6 error-warning and bit 7 bus-off, each one cycle after the input level. CPU writes do not alter them.
- R6: When the error enable is set, any change of bus-off or error-warning, in either direction, makes the status interrupt pending. When the error enable is clear, such a change does not.
- R7: When the status-change enable is set, a sent-OK, received-OK, error-report or recovery-run pulse makes the status interrupt pending. When that enable is clear, these pulses do not.
- R8: A change of error-passive never makes the status interrupt pending.
- R9: A CPU write never makes the status interrupt pending.
- R10: While the interrupt is pending, `irq` is high and `irq_id` is 0x8000. Otherwise `irq` is low and `irq_id` is 0x0000. A pending interrupt stays pending until it is read.
- R11: A read strobe clears the pending interrupt at the next edge. If a new raising event arrives in the same cycle, the interrupt stays pending.
- R12: When a bus event and a CPU write hit the same field in the same cycle, the bus event's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tx_ok | input | 1 | Pulse: frame sent successfully |
| ev_rx_ok | input | 1 | Pulse: frame received successfully |
| ev_err_vld | input | 1 | Pulse: error classification valid |
| ev_err_code | input | 3 | Error code that goes with `ev_err_vld` |
| ev_rec11 | input | 1 | Pulse: 11 recessive bits seen during bus-off recovery |
| lvl_epass | input | 1 | Level: error-passive |
| lvl_ewarn | input | 1 | Level: error-warning |
| lvl_boff | input | 1 | Level: bus-off |
| en_err | input | 1 | Enable for the error interrupt |
| en_stat | input | 1 | Enable for the status-change interrupt |
| cpu_rd | input | 1 | Read strobe of the status word |
| cpu_wr | input | 1 | Write strobe of the status word |
| cpu_wdata | input | 5 | Write data for bits 4:0 |
| stat_word | output | 8 | Status word |
| irq | output | 1 | Interrupt line |
| irq_id | output | 16 | Interrupt identifier |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled at the clock edge. They also assume that `ev_err_code` matters only while `ev_err_vld` is high, and that the levels and enables are synchronous to `clk`. The stimulus drives every input on the falling edge. It raises each pulse for exactly one cycle and toggles the levels independently of the pulses. Reads, writes, events and level changes are deliberately allowed to land in the same cycle, so that the precedence rules of R4, R11 and R12 are exercised.

// File: rtl/can_stat_pkg.sv
`timescale 1ns/1ps
// can_stat_pkg: shared constants and the error-code type of the CAN status block.
// Assumes a status word with the error code in its low bits.
package can_stat_pkg;
    localparam int LEC_W    = 3;          // width of the error-code field
    localparam int TXOK_BIT = LEC_W;      // sent-OK position
    localparam int OK_N     = 2;          // sent-OK, received-OK
    localparam int LVL_BIT  = LEC_W + OK_N; // first level bit (error-passive)
    localparam int LVL_N    = 3;          // error-passive, error-warning, bus-off
    localparam int WORD_W   = LVL_BIT + LVL_N;
    localparam int WR_W     = LEC_W + OK_N; // CPU-writable low bits

    typedef enum logic [LEC_W-1:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_IDLE  = 3'd7
    } lec_e;
endpackage

// File: rtl/can_stat_flags.sv
`timescale 1ns/1ps
// can_stat_flags: holds the status word fields. Bus events set the success
// flags and load the error code. CPU writes load the writable fields, but a
// bus event in the same cycle wins. The three levels are registered once.
// Emits a status-change event and an error-level change for the interrupt logic.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module can_stat_flags
    import can_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_ok,
    input  logic              ev_err_vld,
    input  logic [LEC_W-1:0]  ev_err_code,
    input  logic              ev_rec11,
    input  logic              lvl_epass,
    input  logic              lvl_ewarn,
    input  logic              lvl_boff,
    input  logic              cpu_wr,
    input  logic [WR_W-1:0]   cpu_wdata,
    output logic [WORD_W-1:0] stat_word,
    output logic              sc_evt,
    output logic              err_chg
);
    logic [OK_N-1:0]  ok_ev;
    logic [OK_N-1:0]  ok_q;
    logic [LVL_N-1:0] lvl_in;
    logic [LVL_N-1:0] lvl_q;
    lec_e             lec_q;
    lec_e             lec_d;

    assign ok_ev  = {ev_rx_ok, ev_tx_ok};
    assign lvl_in = {lvl_boff, lvl_ewarn, lvl_epass};

    // Sticky success flags: the event sets the flag, otherwise a CPU write loads it.
    for (genvar i = 0; i < OK_N; i++) begin : g_ok
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (ok_ev[i])
                flag_q <= 1'b1;
            else if (cpu_wr)
                flag_q <= cpu_wdata[TXOK_BIT+i];
        end
        assign ok_q[i] = flag_q;

        AST_OK_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ok_ev[i] |=> ok_q[i]); // R12
    end

    // Level registers: follow the engine's status levels one cycle later.
    for (genvar i = 0; i < LVL_N; i++) begin : g_lvl
        logic lv_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lv_q <= 1'b0;
            else
                lv_q <= lvl_in[i];
        end
        assign lvl_q[i] = lv_q;

        AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (lvl_q[i] == $past(lvl_in[i]))); // R5
    end

    // Next error code: error report first, then recovery run, then the CPU write.
    always_comb begin
        lec_d = lec_q;
        if (ev_err_vld)
            lec_d = lec_e'(ev_err_code);
        else if (ev_rec11)
            lec_d = LEC_BIT0;
        else if (cpu_wr)
            lec_d = lec_e'(cpu_wdata[LEC_W-1:0]);
    end

    // Error-code register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lec_q <= LEC_NONE;
        else
            lec_q <= lec_d;
    end

    // Assemble the status word from the field registers.
    always_comb begin
        stat_word = '0;
        stat_word[LEC_W-1:0] = lec_q;
        for (int i = 0; i < OK_N; i++)
            stat_word[TXOK_BIT+i] = ok_q[i];
        for (int i = 0; i < LVL_N; i++)
            stat_word[LVL_BIT+i] = lvl_q[i];
    end

    // Event outputs toward the interrupt logic. Error-passive (index 0) is excluded.
    assign sc_evt  = ev_tx_ok | ev_rx_ok | ev_err_vld | ev_rec11;
    assign err_chg = (lvl_in[1] != lvl_q[1]) | (lvl_in[2] != lvl_q[2]);

    AST_LEC_TRACKS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err_vld |=> (lec_q == $past(ev_err_code))); // R3
    AST_RECOVERY_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rec11 && !ev_err_vld) |=> (lec_q == LEC_BIT0)); // R4
endmodule

// File: rtl/can_stat_pend.sv
`timescale 1ns/1ps
// can_stat_pend: the pending bit of the status interrupt. Enabled events set
// it, and a read of the status word clears it unless a new event arrives in
// the same cycle. Drives the interrupt line and the identifier.
// Assumes sc_evt and err_chg are valid in the cycle of the event.
module can_stat_pend #(
    parameter int               ID_W    = 16,
    parameter logic [ID_W-1:0]  STAT_ID = 16'h8000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_err,
    input  logic            en_stat,
    input  logic            err_chg,
    input  logic            sc_evt,
    input  logic            cpu_rd,
    output logic            irq,
    output logic [ID_W-1:0] irq_id
);
    logic pend_q;
    logic set_req;

    // Raising condition, gated by the two enables.
    assign set_req = (en_err & err_chg) | (en_stat & sc_evt);

    // Pending bit: a set beats a same-cycle read clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (set_req)
            pend_q <= 1'b1;
        else if (cpu_rd)
            pend_q <= 1'b0;
    end

    // Outputs of the pending state.
    assign irq    = pend_q;
    assign irq_id = pend_q ? STAT_ID : '0;

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past((en_err && err_chg) || (en_stat && sc_evt))); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !(en_err && err_chg) && !(en_stat && sc_evt)) |=> !pend_q); // R11
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !cpu_rd) |=> pend_q); // R10
endmodule

// File: rtl/can_stat_irq.sv
`timescale 1ns/1ps
// can_stat_irq: top of the CAN status word and status interrupt. It connects
// the field registers to the pending logic and exposes a one-register CPU port.
// Assumes all inputs are synchronous to clk and events last one cycle.
module can_stat_irq
    import can_stat_pkg::*;
#(
    parameter int              ID_W    = 16,
    parameter logic [ID_W-1:0] STAT_ID = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_ok,
    input  logic              ev_err_vld,
    input  logic [LEC_W-1:0]  ev_err_code,
    input  logic              ev_rec11,
    input  logic              lvl_epass,
    input  logic              lvl_ewarn,
    input  logic              lvl_boff,
    input  logic              en_err,
    input  logic              en_stat,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [WR_W-1:0]   cpu_wdata,
    output logic [WORD_W-1:0] stat_word,
    output logic              irq,
    output logic [ID_W-1:0]   irq_id
);
    logic sc_evt;
    logic err_chg;

    can_stat_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_tx_ok   (ev_tx_ok),
        .ev_rx_ok   (ev_rx_ok),
        .ev_err_vld (ev_err_vld),
        .ev_err_code(ev_err_code),
        .ev_rec11   (ev_rec11),
        .lvl_epass  (lvl_epass),
        .lvl_ewarn  (lvl_ewarn),
        .lvl_boff   (lvl_boff),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .stat_word  (stat_word),
        .sc_evt     (sc_evt),
        .err_chg    (err_chg)
    );

    can_stat_pend #(
        .ID_W   (ID_W),
        .STAT_ID(STAT_ID)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_err (en_err),
        .en_stat(en_stat),
        .err_chg(err_chg),
        .sc_evt (sc_evt),
        .cpu_rd (cpu_rd),
        .irq    (irq),
        .irq_id (irq_id)
    );

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && cpu_wr && !sc_evt && !err_chg) |=> !irq); // R9
    AST_PASSIVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && (lvl_epass != stat_word[LVL_BIT]) && !sc_evt && !err_chg) |=> !irq); // R8
    AST_ERR_ENABLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_err && err_chg) |=> irq); // R6
endmodule

// File: tb/sim_can_stat_irq.sv
`timescale 1ns/1ps
// sim_can_stat_irq: bench with directed corner cases and seeded random traffic,
// compared against a bench-side model of the requirements.
module sim_can_stat_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_tx_ok = 0, ev_rx_ok = 0, ev_err_vld = 0, ev_rec11 = 0;
    logic [2:0]  ev_err_code = 0;
    logic        lvl_epass = 0, lvl_ewarn = 0, lvl_boff = 0;
    logic        en_err = 0, en_stat = 0, cpu_rd = 0, cpu_wr = 0;
    logic [4:0]  cpu_wdata = 0;
    logic [7:0]  stat_word;
    logic        irq;
    logic [15:0] irq_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state (value after the last edge)
    logic [2:0] m_lec = 0;
    logic       m_tx = 0, m_rx = 0, m_pend = 0;
    logic [2:0] m_lv = 0;

    can_stat_irq u0 (
        .clk(clk), .rst_n(rst_n), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_err_vld(ev_err_vld), .ev_err_code(ev_err_code), .ev_rec11(ev_rec11),
        .lvl_epass(lvl_epass), .lvl_ewarn(lvl_ewarn), .lvl_boff(lvl_boff),
        .en_err(en_err), .en_stat(en_stat), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .stat_word(stat_word), .irq(irq), .irq_id(irq_id)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected next state from the requirements and the present inputs.
    task automatic model_next();
        logic errchg, sc, set;
        errchg = (lvl_ewarn != m_lv[1]) || (lvl_boff != m_lv[2]);
        sc     = ev_tx_ok || ev_rx_ok || ev_err_vld || ev_rec11;
        set    = (en_err && errchg) || (en_stat && sc);
        m_pend = set ? 1'b1 : (cpu_rd ? 1'b0 : m_pend);
        m_tx   = ev_tx_ok ? 1'b1 : (cpu_wr ? cpu_wdata[3] : m_tx);
        m_rx   = ev_rx_ok ? 1'b1 : (cpu_wr ? cpu_wdata[4] : m_rx);
        m_lec  = ev_err_vld ? ev_err_code : (ev_rec11 ? 3'd5 : (cpu_wr ? cpu_wdata[2:0] : m_lec));
        m_lv   = {lvl_boff, lvl_ewarn, lvl_epass};
    endtask

    // One clock: predict, cross the edge, compare at the falling edge, drop strobes.
    task automatic step();
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk("R3 code", {13'd0, stat_word[2:0]}, {13'd0, m_lec});
        chk("R2 ok flags", {14'd0, stat_word[4:3]}, {14'd0, m_rx, m_tx});
        chk("R5 levels", {13'd0, stat_word[7:5]}, {13'd0, m_lv});
        chk("R10 irq", {15'd0, irq}, {15'd0, m_pend});
        chk("R10 id", irq_id, m_pend ? 16'h8000 : 16'h0000);
        ev_tx_ok = 0; ev_rx_ok = 0; ev_err_vld = 0; ev_rec11 = 0;
        cpu_rd = 0; cpu_wr = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int unused_seed;
        unused_seed = $urandom(32'h5eed_c0de);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state after release, nothing driven
        chk("R1 word", {8'd0, stat_word}, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        chk("R1 id", irq_id, 16'h0000);

        // R7: enable clear, sent-OK sets the flag only
        ev_tx_ok = 1; step();
        chk("R7 gated", {15'd0, irq}, 16'h0000);
        // R7/R10: enable set, received-OK raises
        en_stat = 1; ev_rx_ok = 1; step();
        chk("R10 id", irq_id, 16'h8000);
        // R11: read clears
        cpu_rd = 1; step();
        chk("R11 clear", {15'd0, irq}, 16'h0000);
        // R9: CPU write of code 7, flags cleared, no interrupt
        cpu_wr = 1; cpu_wdata = 5'b00111; step();
        chk("R9 silent", {15'd0, irq}, 16'h0000);
        chk("R9 data", {8'd0, stat_word}, 16'h0007);
        step();
        chk("R3 idle holds", {13'd0, stat_word[2:0]}, 16'h0007);
        // R4: recovery run gives bit-0 code and raises
        ev_rec11 = 1; step();
        chk("R4 bit0", {13'd0, stat_word[2:0]}, 16'h0005);
        // R11: read and new error report in the same cycle keeps it pending
        cpu_rd = 1; ev_err_vld = 1; ev_err_code = 3'd1; step();
        chk("R11 set wins", {15'd0, irq}, 16'h0001);
        cpu_rd = 1; step();
        // R8: error-passive change with both enables stays silent
        en_err = 1; lvl_epass = 1; step();
        chk("R8 silent", {15'd0, irq}, 16'h0000);
        chk("R8 level", {15'd0, stat_word[5]}, 16'h0001);
        // R6: bus-off rise and fall both raise
        lvl_boff = 1; step();
        chk("R6 rise", {15'd0, irq}, 16'h0001);
        cpu_rd = 1; step();
        lvl_boff = 0; step();
        chk("R6 fall", {15'd0, irq}, 16'h0001);
        cpu_rd = 1; step();
        en_err = 0; lvl_ewarn = 1; step();
        chk("R6 gated", {15'd0, irq}, 16'h0000);
        // R12: event beats same-cycle write
        en_stat = 0; cpu_wr = 1; cpu_wdata = 5'b00000;
        ev_tx_ok = 1; ev_err_vld = 1; ev_err_code = 3'd6; step();
        chk("R12 flag", {15'd0, stat_word[3]}, 16'h0001);
        chk("R12 code", {13'd0, stat_word[2:0]}, 16'h0006);
        // R4: error report beats recovery run
        ev_err_vld = 1; ev_err_code = 3'd2; ev_rec11 = 1; step();
        chk("R4 priority", {13'd0, stat_word[2:0]}, 16'h0002);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            en_err      = ($urandom % 2) == 0;
            en_stat     = ($urandom % 2) == 0;
            ev_tx_ok    = ($urandom % 8) == 0;
            ev_rx_ok    = ($urandom % 8) == 0;
            ev_err_vld  = ($urandom % 6) == 0;
            ev_err_code = 3'($urandom % 8);
            ev_rec11    = ($urandom % 10) == 0;
            if (($urandom % 16) == 0) lvl_epass = ~lvl_epass;
            if (($urandom % 16) == 0) lvl_ewarn = ~lvl_ewarn;
            if (($urandom % 16) == 0) lvl_boff  = ~lvl_boff;
            cpu_rd      = ($urandom % 4) == 0;
            cpu_wr      = ($urandom % 8) == 0;
            cpu_wdata   = 5'($urandom % 32);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule